// File: doc/BRIEF.md
# Banked Digital I/O Register Block with Edge Capture

This block sits on an 8-bit host register bus and serves 48 digital lines arranged as six byte ports. Each port is one register. Writing a port sets the pull-down drive for its eight lines. Reading a port returns the synchronized pin levels. Both directions use inverted sense. A 1 written to a port bit pulls the line low. A line that reads 0 is an asserted input.

The lower 24 lines can also raise interrupts. A control register holds two fields: a 2-bit page number and per-port write locks. The page number selects what a three-byte window shows: per-line edge polarity, per-line interrupt enable, or the latched identification bits of lines that have fired. When an enabled line shows its chosen edge, its identification bit sets and stays set until the host clears it through the window. A pending register gives one summary bit per byte group, and the `irq` output is high while any identification bit is set.

Top module: `pdio_top`

## Requirements
- R1: A bus write to port address 0x10+p (p = 0..5) whose lock bit is clear places the data byte on `pin_pull_low[8p+7:8p]` at the next clock edge. Without a write, `pin_pull_low` does not change.
- R2: A write to port p while lock bit p of the control register (bit p of address 0x17) is set leaves `pin_pull_low` unchanged.
- R3: Reading address 0x10+p returns byte p of `pin_in`, delayed by two register stages. A pin change is visible on the second clock edge after it.
- R4: Address 0x17 reads back the last value written to it: page number in bits 7:6 and lock bits in bits 5:0. Unmapped addresses read 0.
- R5: With page 1 (polarity) or page 2 (enable) selected, window addresses 0x18, 0x19 and 0x1A write and read line bits 7:0, 15:8 and 23:16 of that bank.
- R6: With page 0 selected, the window reads 0 and writes to it change no bank.
- R7: A polarity bit of 1 selects the rising edge and 0 the falling edge. An edge on an enabled line among lines 0..23 sets its identification bit on the third clock edge after the pin change. A line with its enable bit at 0 never sets its bit.
- R8: An identification bit stays set until a page-3 window write carries 0 in that bit position; written 1s keep their bits. A new edge in the same cycle as a clear leaves the bit set.
- R9: Address 0x16 reads bit g (g = 0..2) as the OR of identification bits 8g+7..8g. Bits 7:3 read 0.
- R10: `irq` is 1 exactly when at least one identification bit is set.
- R11: After reset, all ports, banks, identification bits, page and lock fields are 0, so `pin_pull_low` is 0 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 5 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| pin_in | input | 48 | Asynchronous line levels |
| pin_pull_low | output | 48 | 1 pulls the line low |
| irq | output | 1 | Interrupt request, OR of identification bits |

## Verification
The bench builds the block at its defaults: six ports, three interrupt-capable byte groups, and a two-stage synchronizer. At these values the whole address map from 0x10 to 0x1A is in use, all three pending bits can be set, and every lock bit guards a real port. The three-cycle latency from pin to identification bit is then a fixed number that the reference model can follow exactly while random bus traffic and random pin changes overlap.

// File: rtl/pdio_pkg.sv
package pdio_pkg;
    localparam int ADDR_W = 5;

    typedef enum logic [1:0] {
        PG_DIRECT   = 2'd0,
        PG_POLARITY = 2'd1,
        PG_ENABLE   = 2'd2,
        PG_IDENT    = 2'd3
    } page_e;

    localparam logic [ADDR_W-1:0] ADDR_PORT0 = 5'h10;
    localparam logic [ADDR_W-1:0] ADDR_PEND  = 5'h16;
    localparam logic [ADDR_W-1:0] ADDR_PAGE  = 5'h17;
    localparam logic [ADDR_W-1:0] ADDR_WIN0  = 5'h18;
    localparam int               LOCK_W     = 6;
endpackage

// File: rtl/pdio_sync.sv
module pdio_sync #(
    parameter int WIDTH  = 48,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = async_in;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/pdio_edge_id.sv
module pdio_edge_id #(
    parameter int WIDTH = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] level,
    input  logic [WIDTH-1:0] polarity,
    input  logic [WIDTH-1:0] enable,
    input  logic [WIDTH-1:0] clear_mask,
    output logic [WIDTH-1:0] id_bits
);
    typedef struct packed {
        logic [WIDTH-1:0] prev;
        logic [WIDTH-1:0] id;
    } edge_state_t;

    edge_state_t st_d, st_q;
    logic [WIDTH-1:0] rise, fall, hit;

    always_comb begin
        rise    = level & ~st_q.prev;
        fall    = ~level & st_q.prev;
        hit     = enable & ((polarity & rise) | (~polarity & fall));
        st_d    = st_q;
        st_d.prev = level;
        // a fresh edge outranks a clear in the same cycle
        st_d.id = (st_q.id & ~clear_mask) | hit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign id_bits = st_q.id;
endmodule

// File: rtl/pdio_top.sv
module pdio_top
    import pdio_pkg::*;
#(
    parameter int NUM_PORTS   = 6,
    parameter int IRQ_PORTS   = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [4:0]             bus_addr,
    input  logic                   bus_wr,
    input  logic [7:0]             bus_wdata,
    output logic [7:0]             bus_rdata,
    input  logic [8*NUM_PORTS-1:0] pin_in,
    output logic [8*NUM_PORTS-1:0] pin_pull_low,
    output logic                   irq
);
    localparam int PIN_W = 8 * NUM_PORTS;
    localparam int IRQ_W = 8 * IRQ_PORTS;

    typedef struct packed {
        logic [PIN_W-1:0]  port;
        page_e             page;
        logic [LOCK_W-1:0] lock;
        logic [IRQ_W-1:0]  pol;
        logic [IRQ_W-1:0]  ena;
    } regs_t;

    regs_t r_d, r_q;

    logic [PIN_W-1:0]     pin_level;
    logic [IRQ_W-1:0]     id_bits;
    logic [IRQ_W-1:0]     id_clear;
    logic [IRQ_PORTS-1:0] pend;

    pdio_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES)) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pin_level)
    );

    pdio_edge_id #(.WIDTH(IRQ_W)) edge_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .level      (pin_level[IRQ_W-1:0]),
        .polarity   (r_q.pol),
        .enable     (r_q.ena),
        .clear_mask (id_clear),
        .id_bits    (id_bits)
    );

    for (genvar g = 0; g < IRQ_PORTS; g++) begin : g_pend
        assign pend[g] = |id_bits[8*g +: 8];
    end

    assign irq          = |pend;
    assign pin_pull_low = r_q.port;

    // register write decode
    always_comb begin
        r_d      = r_q;
        id_clear = '0;
        if (bus_wr) begin
            for (int p = 0; p < NUM_PORTS; p++) begin
                if (bus_addr == ADDR_PORT0 + 5'(p) && !r_q.lock[p]) begin
                    r_d.port[8*p +: 8] = bus_wdata;
                end
            end
            if (bus_addr == ADDR_PAGE) begin
                r_d.page = page_e'(bus_wdata[7:6]);
                r_d.lock = bus_wdata[LOCK_W-1:0];
            end
            for (int k = 0; k < IRQ_PORTS; k++) begin
                if (bus_addr == ADDR_WIN0 + 5'(k)) begin
                    case (r_q.page)
                        PG_POLARITY: r_d.pol[8*k +: 8] = bus_wdata;
                        PG_ENABLE:   r_d.ena[8*k +: 8] = bus_wdata;
                        PG_IDENT:    id_clear[8*k +: 8] = ~bus_wdata;
                        default:     ;
                    endcase
                end
            end
        end
    end

    // read mux
    always_comb begin
        bus_rdata = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (bus_addr == ADDR_PORT0 + 5'(p)) bus_rdata = pin_level[8*p +: 8];
        end
        if (bus_addr == ADDR_PEND) bus_rdata = 8'(pend);
        if (bus_addr == ADDR_PAGE) bus_rdata = {r_q.page, r_q.lock};
        for (int k = 0; k < IRQ_PORTS; k++) begin
            if (bus_addr == ADDR_WIN0 + 5'(k)) begin
                case (r_q.page)
                    PG_POLARITY: bus_rdata = r_q.pol[8*k +: 8];
                    PG_ENABLE:   bus_rdata = r_q.ena[8*k +: 8];
                    PG_IDENT:    bus_rdata = id_bits[8*k +: 8];
                    default:     bus_rdata = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end
endmodule

// File: rtl/pdio_chk.sv
module pdio_chk
    import pdio_pkg::*;
#(
    parameter int NUM_PORTS = 6,
    parameter int IRQ_PORTS = 3
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [4:0]             bus_addr,
    input logic                   bus_wr,
    input logic [7:0]             bus_rdata,
    input logic [8*NUM_PORTS-1:0] pin_pull_low,
    input logic                   irq,
    input logic [1:0]             page,
    input logic [LOCK_W-1:0]      lock,
    input logic [8*IRQ_PORTS-1:0] pol,
    input logic [8*IRQ_PORTS-1:0] ena
);
    logic in_win, port_locked;

    always_comb begin
        in_win      = (bus_addr >= ADDR_WIN0) && (bus_addr < ADDR_WIN0 + 5'(IRQ_PORTS));
        port_locked = 1'b0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (bus_addr == ADDR_PORT0 + 5'(p) && lock[p]) port_locked = 1'b1;
        end
    end

    assert_pull_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> $stable(pin_pull_low));

    assert_locked_port_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && port_locked |=> $stable(pin_pull_low));

    assert_page0_inert_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && in_win && page == 2'd0 |=> $stable(pol) && $stable(ena));

    assert_no_enable_no_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !irq && ena == '0 |=> !irq);

    assert_irq_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !(bus_wr && in_win && page == 2'd3) |=> irq);

    assert_pend_summary_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_addr == ADDR_PEND |-> (bus_rdata[7:IRQ_PORTS] == '0) && ((bus_rdata != 8'd0) == irq));
endmodule

bind pdio_top pdio_chk #(.NUM_PORTS(NUM_PORTS), .IRQ_PORTS(IRQ_PORTS)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_addr     (bus_addr),
    .bus_wr       (bus_wr),
    .bus_rdata    (bus_rdata),
    .pin_pull_low (pin_pull_low),
    .irq          (irq),
    .page         (r_q.page),
    .lock         (r_q.lock),
    .pol          (r_q.pol),
    .ena          (r_q.ena)
);

// File: tb/pdio_top_tb_top.sv
module pdio_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [47:0] pin_in = '0;
    logic [47:0] pin_pull_low;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit mon_en = 1'b0;

    pdio_top dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_pull_low(pin_pull_low), .irq(irq)
    );

    always #10 clk = ~clk;

    // behavioural reference model
    logic [47:0] m_port;
    logic [1:0]  m_page;
    logic [5:0]  m_lock;
    logic [23:0] m_pol, m_ena, m_id;
    logic [47:0] hist[$];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_port = '0; m_page = '0; m_lock = '0;
            m_pol = '0; m_ena = '0; m_id = '0;
            hist = '{48'd0, 48'd0, 48'd0};
        end else begin
            logic [23:0] lv, pv, hit, clr;
            lv  = hist[1][23:0];
            pv  = hist[0][23:0];
            hit = m_ena & ((m_pol & lv & ~pv) | (~m_pol & ~lv & pv));
            clr = '0;
            if (bus_wr) begin
                if (bus_addr >= 5'h10 && bus_addr <= 5'h15) begin
                    if (!m_lock[bus_addr - 5'h10]) m_port[8*(bus_addr - 5'h10) +: 8] = bus_wdata;
                end
                if (bus_addr == 5'h17) begin
                    m_page = bus_wdata[7:6];
                    m_lock = bus_wdata[5:0];
                end else if (bus_addr >= 5'h18 && bus_addr <= 5'h1A) begin
                    case (m_page)
                        2'd1: m_pol[8*(bus_addr - 5'h18) +: 8] = bus_wdata;
                        2'd2: m_ena[8*(bus_addr - 5'h18) +: 8] = bus_wdata;
                        2'd3: clr[8*(bus_addr - 5'h18) +: 8] = ~bus_wdata;
                        default: ;
                    endcase
                end
            end
            m_id = (m_id & ~clr) | hit;
            hist.push_back(pin_in);
            void'(hist.pop_front());
        end
    end

    function automatic logic [7:0] exp_rd(logic [4:0] a);
        if (a >= 5'h10 && a <= 5'h15) return hist[1][8*(a - 5'h10) +: 8];
        if (a == 5'h16) return {5'd0, |m_id[23:16], |m_id[15:8], |m_id[7:0]};
        if (a == 5'h17) return {m_page, m_lock};
        if (a >= 5'h18 && a <= 5'h1A) begin
            case (m_page)
                2'd1: return m_pol[8*(a - 5'h18) +: 8];
                2'd2: return m_ena[8*(a - 5'h18) +: 8];
                2'd3: return m_id[8*(a - 5'h18) +: 8];
                default: return 8'd0;
            endcase
        end
        return 8'd0;
    endfunction

    function automatic string tag_of(logic [4:0] a);
        if (a >= 5'h10 && a <= 5'h15) return "R3";
        if (a == 5'h16) return "R9";
        if (a >= 5'h18 && a <= 5'h1A) begin
            case (m_page)
                2'd0: return "R6";
                2'd3: return "R8";
                default: return "R5";
            endcase
        end
        return "R4";
    endfunction

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && mon_en) begin
            #5;
            chk(tag_of(bus_addr), "rdata", 64'(bus_rdata), 64'(exp_rd(bus_addr)));
            chk("R1", "pin_pull_low", 64'(pin_pull_low), 64'(m_port));
            chk("R10", "irq", 64'(irq), 64'(|m_id));
        end
    end

    task automatic wr(logic [4:0] a, logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [4:0] a, output logic [7:0] d);
        bus_addr = a;
        #2;
        d = bus_rdata;
    endtask

    initial begin
        #(20 * 150000);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] d;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        mon_en = 1'b1;

        // R11: reset state
        chk("R11", "pull_low after reset", 64'(pin_pull_low), 64'd0);
        chk("R11", "irq after reset", 64'(irq), 64'd0);
        rd(5'h17, d); chk("R11", "page reg after reset", 64'(d), 64'd0);
        rd(5'h16, d); chk("R11", "pending after reset", 64'(d), 64'd0);

        // R1: port writes
        for (int i = 0; i < 6; i++) wr(5'h10 + 5'(i), 8'(8'h11 * (i + 1)));
        chk("R1", "all ports", 64'(pin_pull_low), 64'h665544332211);

        // R2: lock port 1
        wr(5'h17, 8'h02);
        wr(5'h11, 8'hFF);
        chk("R2", "locked port unchanged", 64'(pin_pull_low), 64'h665544332211);
        wr(5'h17, 8'h00);
        wr(5'h11, 8'h7E);
        chk("R2", "unlocked port written", 64'(pin_pull_low[15:8]), 64'h7E);

        // R3: pin read latency
        pin_in = 48'hC3_A5_5A_0F_F0_00;
        @(negedge clk);
        rd(5'h12, d); chk("R3", "one edge after change", 64'(d), 64'h00);
        @(negedge clk);
        rd(5'h12, d); chk("R3", "two edges after change", 64'(d), 64'h0F);
        rd(5'h15, d); chk("R3", "port 5", 64'(d), 64'hC3);
        pin_in = '0;
        repeat (4) @(negedge clk);

        // R4: control register readback
        wr(5'h17, 8'h45);
        rd(5'h17, d); chk("R4", "page/lock readback", 64'(d), 64'h45);
        rd(5'h0C, d); chk("R4", "unmapped address", 64'(d), 64'h00);
        wr(5'h17, 8'h00);

        // R5: polarity and enable banks
        wr(5'h17, 8'h40);
        wr(5'h18, 8'h0F); wr(5'h19, 8'h00); wr(5'h1A, 8'h01);
        rd(5'h1A, d); chk("R5", "polarity byte 2", 64'(d), 64'h01);
        wr(5'h17, 8'h80);
        wr(5'h18, 8'h33); wr(5'h1A, 8'h01);
        rd(5'h18, d); chk("R5", "enable byte 0", 64'(d), 64'h33);

        // R6: page 0 window inert
        wr(5'h17, 8'h00);
        wr(5'h18, 8'hFF);
        rd(5'h18, d); chk("R6", "page 0 reads zero", 64'(d), 64'h00);
        wr(5'h17, 8'h40);
        rd(5'h18, d); chk("R6", "polarity untouched", 64'(d), 64'h0F);
        wr(5'h17, 8'h80);
        rd(5'h18, d); chk("R6", "enable untouched", 64'(d), 64'h33);

        // R7: edge capture; lines 0,1 rising, 4,5 falling enabled, 2,3 disabled
        wr(5'h17, 8'hC0);
        pin_in[7:0] = 8'hFF;
        @(negedge clk); @(negedge clk);
        chk("R7", "no id before third edge", 64'(irq), 64'd0);
        @(negedge clk);
        chk("R10", "irq on third edge", 64'(irq), 64'd1);
        rd(5'h18, d); chk("R7", "rising ids", 64'(d), 64'h03);
        pin_in[7:0] = 8'h00;
        repeat (4) @(negedge clk);
        rd(5'h18, d); chk("R7", "falling ids added", 64'(d), 64'h33);

        // R9: group 2 pending
        pin_in[16] = 1'b1;
        repeat (4) @(negedge clk);
        rd(5'h16, d); chk("R9", "pending groups 0 and 2", 64'(d), 64'h05);

        // R8: partial and full clear
        wr(5'h18, 8'h30);
        rd(5'h18, d); chk("R8", "partial clear", 64'(d), 64'h30);
        wr(5'h18, 8'h00); wr(5'h1A, 8'h00);
        chk("R10", "irq after full clear", 64'(irq), 64'd0);
        rd(5'h16, d); chk("R9", "pending after clear", 64'(d), 64'h00);

        // random traffic against the model
        for (int n = 0; n < 600; n++) begin
            bus_addr  = 5'h10 + 5'($urandom % 11);
            bus_wdata = 8'($urandom);
            bus_wr    = ($urandom % 3) == 0;
            if (bus_addr == 5'h17 && bus_wr) bus_wdata[5:0] = bus_wdata[5:0] & 6'h09;
            if (n % 3 == 0) pin_in = {16'($urandom), 32'($urandom)};
            @(negedge clk);
        end
        bus_wr = 1'b0;
        @(negedge clk);
        mon_en = 1'b0;

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule